// File: doc/BRIEF.md
# Receive FIFO Index and Status Tracker

This block keeps the bookkeeping for a circular receive queue whose elements live in a separate message RAM that holds up to 64 elements. It does not store any message data. When the receive path wants to store a frame, it raises a one-cycle store request. The block shows the slot to write on `put_idx` and then advances its put index. Software reads a packed status word and handles the oldest element, which sits at the get index. It then writes that element's index to the acknowledge input, and that frees the element together with every older one still held.

Loading a new configuration sets the queue size and the watermark and clears all state. A store to a full queue is dropped, and the sticky message-lost flag records it. Four event pulses report the following:
- each accepted store,
- the fill level reaching the watermark,
- the queue becoming full,
- a dropped store.

Top module: `rxq_index_tracker`

## Requirements
- R1: After reset the status word is all zero, `put_idx` is 0, every event output is low, and the size is 0.
- R2: A `cfg_apply` pulse loads `cfg_size` (values above the DEPTH parameter are limited to DEPTH) and `cfg_wmark`, and clears the put index, get index, level and lost flag. A store or acknowledge in the same cycle is ignored.
- R3: A store request is accepted when the size is nonzero and the level is below the size. `put_idx` then names the slot to write. After the clock edge the put index has advanced by one (wrapping from size-1 to 0), the level has risen by one, and `ev_new` is high for that one cycle.
- R4: A store request with the level equal to the size, or with a size of 0, is dropped. Put index and level stay as they were. The lost flag is set, and `ev_lost` pulses for one cycle. The lost flag stays set until the next `cfg_apply`.
- R5: An acknowledge of index A frees N = ((A - get) mod size) + 1 elements. The get index becomes (A + 1) mod size and the level drops by N.
- R6: An acknowledge is ignored when the level is 0, when A is not below the size, or when N exceeds the level. Get index and level then stay unchanged.
- R7: An accepted store and a valid acknowledge in the same cycle both take effect. The new level is level + 1 - N, so it is unchanged when N is 1.
- R8: Status word layout: level in bits 6:0, get index in bits 13:8, put index in bits 21:16, full in bit 24, lost in bit 25, and every other bit 0.
- R9: The full bit is 1 when the size is nonzero and the level equals the size. `ev_full` pulses for one cycle when the level becomes equal to the size from a different value.
- R10: `ev_wmark` pulses for one cycle when the level becomes equal to a nonzero watermark from a different value. A watermark of 0 never produces the event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_apply | input | 1 | Load configuration and clear queue state |
| cfg_size | input | 7 | Queue size in elements, 0 disables the queue |
| cfg_wmark | input | 7 | Watermark level, 0 disables the event |
| store_req | input | 1 | Receive side asks to store one element |
| put_idx | output | 6 | Slot the next accepted store writes |
| ack_wr | input | 1 | Software acknowledge strobe |
| ack_idx | input | 6 | Index of the newest element being freed |
| status | output | 32 | Packed level, indices, full and lost |
| ev_new | output | 1 | Pulse: a store was accepted |
| ev_wmark | output | 1 | Pulse: level reached the watermark |
| ev_full | output | 1 | Pulse: queue became full |
| ev_lost | output | 1 | Pulse: a store was dropped |

## Verification
The bench pushes the put index past its wrap point at sizes 4 and 64. A tracker that wraps at 64 instead of at the configured size would hand out slots outside the queue. The bench acknowledges several elements at once, acknowledges an index that lies behind the get index, and acknowledges an index beyond the size. A design that always subtracts one, or that accepts stale indices, would corrupt the level. The bench also pairs a store with an acknowledge in one cycle, and it stores into a full queue and into a disabled queue. A design that lets one side win, or that clears the lost flag too early, would show the wrong level or lose the lost bit before reconfiguration.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int IDX_W = 6;
  localparam int LVL_W = IDX_W + 1;

  localparam int ST_LVL_LSB  = 0;
  localparam int ST_GET_LSB  = 8;
  localparam int ST_PUT_LSB  = 16;
  localparam int ST_FULL_BIT = 24;
  localparam int ST_LOST_BIT = 25;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [LVL_W-1:0] lvl_t;

  // Next slot after i in a ring of the given size.
  function automatic idx_t idx_step(idx_t i, lvl_t size);
    lvl_t n;
    n = {1'b0, i} + lvl_t'(1);
    return (n >= size) ? '0 : n[IDX_W-1:0];
  endfunction

  // Number of elements from 'from' up to and including 'to' around the ring.
  function automatic lvl_t span_len(idx_t from, idx_t to, lvl_t size);
    lvl_t f;
    lvl_t t;
    f = {1'b0, from};
    t = {1'b0, to};
    return (t >= f) ? (t - f + lvl_t'(1)) : (t + size - f + lvl_t'(1));
  endfunction

  function automatic logic [31:0] pack_status(lvl_t lvl, idx_t get, idx_t put,
                                              logic full, logic lost);
    logic [31:0] w;
    w = '0;
    w[ST_LVL_LSB +: LVL_W] = lvl;
    w[ST_GET_LSB +: IDX_W] = get;
    w[ST_PUT_LSB +: IDX_W] = put;
    w[ST_FULL_BIT]         = full;
    w[ST_LOST_BIT]         = lost;
    return w;
  endfunction
endpackage

// File: rtl/rxq_store_gate.sv
module rxq_store_gate
  import rxq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic store_req,
  input  logic apply,
  input  lvl_t size,
  input  lvl_t lvl,
  output logic accept,
  output logic drop
);
  logic room;

  assign room   = (size != '0) && (lvl < size);
  assign accept = store_req && !apply && room;
  assign drop   = store_req && !apply && !room;

  // R3/R4: a request is either taken or dropped, never both
  a_r3_accept_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && drop));
endmodule

// File: rtl/rxq_ack_decode.sv
module rxq_ack_decode
  import rxq_pkg::*;
(
  input  logic ack_wr,
  input  logic apply,
  input  idx_t ack_idx,
  input  idx_t get_cur,
  input  lvl_t lvl,
  input  lvl_t size,
  output logic rel_ok,
  output lvl_t rel_cnt,
  output idx_t get_nxt
);
  logic in_range;

  assign in_range = ({1'b0, ack_idx} < size);
  assign rel_cnt  = span_len(get_cur, ack_idx, size);
  assign get_nxt  = idx_step(ack_idx, size);
  assign rel_ok   = ack_wr && !apply && (lvl != '0) && in_range && (rel_cnt <= lvl);
endmodule

// File: rtl/rxq_event_gen.sv
module rxq_event_gen
  import rxq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic apply,
  input  logic accept,
  input  logic drop,
  input  lvl_t lvl_cur,
  input  lvl_t lvl_nxt,
  input  lvl_t size,
  input  lvl_t wm,
  output logic ev_new,
  output logic ev_wmark,
  output logic ev_full,
  output logic ev_lost
);
  logic hit_wm;
  logic hit_full;

  assign hit_wm   = (wm != '0) && (lvl_nxt == wm) && (lvl_cur != wm);
  assign hit_full = (size != '0) && (lvl_nxt == size) && (lvl_cur != size);

  always_ff @(posedge clk) begin
    if (!rst_n || apply) begin
      ev_new   <= 1'b0;
      ev_wmark <= 1'b0;
      ev_full  <= 1'b0;
      ev_lost  <= 1'b0;
    end else begin
      ev_new   <= accept;
      ev_wmark <= hit_wm;
      ev_full  <= hit_full;
      ev_lost  <= drop;
    end
  end

  // R10: no watermark event while the watermark is 0
  a_r10_wm_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wmark |-> (wm != '0));
  // R4: a drop and an accept never pulse together
  a_r4_lost_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_lost && ev_new));
endmodule

// File: rtl/rxq_index_tracker.sv
module rxq_index_tracker
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_apply,
  input  logic [6:0]  cfg_size,
  input  logic [6:0]  cfg_wmark,
  input  logic        store_req,
  output logic [5:0]  put_idx,
  input  logic        ack_wr,
  input  logic [5:0]  ack_idx,
  output logic [31:0] status,
  output logic        ev_new,
  output logic        ev_wmark,
  output logic        ev_full,
  output logic        ev_lost
);
  localparam lvl_t CAP = lvl_t'(DEPTH);

  lvl_t size_q, wm_q, lvl_q, lvl_nxt, rel_cnt, size_in;
  idx_t put_q, get_q, get_nxt;
  logic lost_q, accept, drop, rel_ok, full_now;

  assign size_in  = (cfg_size > CAP) ? CAP : cfg_size;
  assign full_now = (size_q != '0) && (lvl_q == size_q);

  rxq_store_gate u_gate (
    .clk(clk), .rst_n(rst_n), .store_req(store_req), .apply(cfg_apply),
    .size(size_q), .lvl(lvl_q), .accept(accept), .drop(drop)
  );

  rxq_ack_decode u_ack (
    .ack_wr(ack_wr), .apply(cfg_apply), .ack_idx(ack_idx), .get_cur(get_q),
    .lvl(lvl_q), .size(size_q), .rel_ok(rel_ok), .rel_cnt(rel_cnt),
    .get_nxt(get_nxt)
  );

  always_comb begin
    lvl_nxt = lvl_q;
    if (accept) lvl_nxt = lvl_nxt + lvl_t'(1);
    if (rel_ok) lvl_nxt = lvl_nxt - rel_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      wm_q   <= '0;
      put_q  <= '0;
      get_q  <= '0;
      lvl_q  <= '0;
      lost_q <= 1'b0;
    end else if (cfg_apply) begin
      size_q <= size_in;
      wm_q   <= cfg_wmark;
      put_q  <= '0;
      get_q  <= '0;
      lvl_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (accept) put_q <= idx_step(put_q, size_q);
      if (rel_ok) get_q <= get_nxt;
      lvl_q <= lvl_nxt;
      if (drop) lost_q <= 1'b1;
    end
  end

  rxq_event_gen u_ev (
    .clk(clk), .rst_n(rst_n), .apply(cfg_apply), .accept(accept), .drop(drop),
    .lvl_cur(lvl_q), .lvl_nxt(lvl_nxt), .size(size_q), .wm(wm_q),
    .ev_new(ev_new), .ev_wmark(ev_wmark), .ev_full(ev_full), .ev_lost(ev_lost)
  );

  assign put_idx = put_q;
  assign status  = pack_status(lvl_q, get_q, put_q, full_now, lost_q);

  // R3: level never exceeds the configured size
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= size_q);
  // R2: reconfiguration leaves an empty, clean queue
  a_r2_apply_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_apply |=> (lvl_q == '0) && (put_q == '0) && (get_q == '0) && !lost_q);
  // R4: a dropped store leaves put index and level alone and sets lost
  a_r4_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rel_ok) |=> $stable(put_q) && $stable(lvl_q) && lost_q);
  // R4: lost flag is sticky until reconfiguration
  a_r4_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !cfg_apply) |=> lost_q);
  // R6: a rejected acknowledge changes nothing
  a_r6_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !rel_ok && !accept && !cfg_apply) |=> $stable(get_q) && $stable(lvl_q));
  // R7: store plus single-element release keeps the level
  a_r7_paired_level: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rel_ok && rel_cnt == lvl_t'(1)) |=> $stable(lvl_q));
  // R9: full event coincides with a full queue
  a_r9_full_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |-> status[ST_FULL_BIT]);
endmodule

// File: tb/tb_rxq_index_tracker.sv
module tb_rxq_index_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_apply = 1'b0;
  logic [6:0] cfg_size = '0;
  logic [6:0] cfg_wmark = '0;
  logic store_req = 1'b0;
  logic ack_wr = 1'b0;
  logic [5:0] ack_idx = '0;
  logic [5:0] put_idx;
  logic [31:0] status;
  logic ev_new, ev_wmark, ev_full, ev_lost;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_size = 0, m_wm = 0, m_put = 0, m_get = 0, m_lvl = 0;
  bit m_lost = 0;
  bit e_new = 0, e_wm = 0, e_full = 0, e_lost = 0;

  always #5 clk = ~clk;

  rxq_index_tracker dut (
    .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .cfg_size(cfg_size),
    .cfg_wmark(cfg_wmark), .store_req(store_req), .put_idx(put_idx),
    .ack_wr(ack_wr), .ack_idx(ack_idx), .status(status), .ev_new(ev_new),
    .ev_wmark(ev_wmark), .ev_full(ev_full), .ev_lost(ev_lost)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] w;
    w = '0;
    w[6:0]   = m_lvl[6:0];
    w[13:8]  = m_get[5:0];
    w[21:16] = m_put[5:0];
    w[24]    = (m_size != 0) && (m_lvl == m_size);
    w[25]    = m_lost;
    chk(tag, "status", status, w);
    chk(tag, "put_idx", put_idx, m_put);
    chk(tag, "events", {ev_new, ev_wmark, ev_full, ev_lost}, {e_new, e_wm, e_full, e_lost});
  endtask

  // One clock of stimulus: drive, update the model, sample at the next falling edge.
  task automatic step(input bit st, input bit ak, input int ai, input bit ap,
                      input int sz, input int wm, input string tag);
    int old, cnt;
    bit acc, drp, okack;
    store_req = st; ack_wr = ak; ack_idx = ai[5:0];
    cfg_apply = ap; cfg_size = sz[6:0]; cfg_wmark = wm[6:0];
    e_new = 0; e_wm = 0; e_full = 0; e_lost = 0;
    if (ap) begin
      m_size = (sz > 64) ? 64 : sz;
      m_wm = wm; m_put = 0; m_get = 0; m_lvl = 0; m_lost = 0;
    end else begin
      old = m_lvl;
      acc = st && (m_size != 0) && (m_lvl < m_size);
      drp = st && !acc;
      okack = 0; cnt = 0;
      if (ak && m_lvl > 0 && ai < m_size) begin
        cnt = ((ai - m_get + m_size) % m_size) + 1;
        okack = (cnt <= m_lvl);
      end
      if (acc) m_put = (m_put + 1) % m_size;
      if (okack) m_get = (ai + 1) % m_size;
      m_lvl = m_lvl + (acc ? 1 : 0) - (okack ? cnt : 0);
      if (drp) m_lost = 1;
      e_new  = acc;
      e_lost = drp;
      e_full = (m_size != 0) && (m_lvl == m_size) && (old != m_size);
      e_wm   = (m_wm != 0) && (m_lvl == m_wm) && (old != m_wm);
    end
    @(posedge clk);
    @(negedge clk);
    store_req = 0; ack_wr = 0; cfg_apply = 0;
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    step(0, 0, 0, 1, 4, 3, "R2");
    step(1, 0, 0, 0, 4, 3, "R3");
    step(1, 0, 0, 0, 4, 3, "R3");
    step(1, 0, 0, 0, 4, 3, "R10");
    step(1, 0, 0, 0, 4, 3, "R9");
    step(1, 0, 0, 0, 4, 3, "R4");
    step(0, 1, 0, 0, 4, 3, "R5");
    step(0, 1, 2, 0, 4, 3, "R5");
    step(0, 1, 2, 0, 4, 3, "R6");
    step(0, 1, 5, 0, 4, 3, "R6");
    step(1, 1, 3, 0, 4, 3, "R7");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 4, 3, "R3");
    step(1, 1, 0, 0, 4, 3, "R7");
    step(0, 1, 1, 0, 4, 3, "R5");
    step(0, 0, 0, 0, 4, 3, "R8");

    step(0, 0, 0, 1, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R4");

    step(1, 1, 0, 1, 64, 0, "R2");
    for (int i = 0; i < 64; i++) step(1, 0, 0, 0, 64, 0, (i == 63) ? "R9" : "R10");
    step(1, 0, 0, 0, 64, 0, "R4");
    step(0, 1, 63, 0, 64, 0, "R5");
    step(0, 1, 0, 0, 64, 0, "R6");

    step(0, 0, 0, 1, 70, 2, "R2");
    for (int i = 0; i < 66; i++) step(1, 0, 0, 0, 70, 2, "R3");
    step(0, 1, 40, 0, 70, 2, "R5");
    step(1, 0, 0, 0, 70, 2, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule